// File: doc/BRIEF.md
# Key-Protected VID Control Registers

This block is a small bank of registers on an indexed register bus. It sets the voltage-identification (VID) code that a core voltage regulator is given. A control register sets the clock source, the family of processor, whether the output follows a base-plus-offset calculation or a directly written code, and whether the extended code table is in use. The mode bits that can upset the supply (bits 2, 1 and 0 of the control register) are guarded. A write to them takes effect only after software has placed an unlock value in a key register, and each such write uses up the key.

In direct mode the output is the value held in the data register. When on-the-fly mode is switched on, the block keeps the direct code that was current at that moment as a base. From then on the output is that base plus a signed offset, clamped to the legal code range. Two external event inputs put the guarded bits back to their defaults: one marks a slot-occupied deassertion, the other a watchdog timeout. Two further byte registers hold the device base address.

Top module: `vid_key_ctrl`

## Requirements
- R1: After reset the control register (index 00h) reads 01h. The offset (01h), data (02h), key (03h), base-high (60h) and base-low (61h) registers read 00h, and `vidOut` is 0.
- R2: Control bit 7 (`clkSelExt`, 1 = external clock) can be written at any time. Control bits 6 to 4 always read 0 and ignore writes.
- R3: Control bit 3 (`otfPinEn`) takes a written value only if control bit 1 is 0 in the cycle of the write. Otherwise it keeps its old value.
- R4: Control bits 2 (`cpuFamily`), 1 (`otfMode`) and 0 (`extTable`) take written values only when the key register at 03h holds 5Ah. The key register reads back the last value written to it.
- R5: A write to the guarded bits that takes effect clears the key register to 00h. A blocked write leaves the key as it was.
- R6: When control bit 1 is 0, `vidOut` equals the 7-bit data register at 02h. Data bit 7 reads 0 and is dropped on write.
- R7: When control bit 1 is 1, `vidOut` is the base plus the offset register (01h) taken as a signed 8-bit number. The base is the data register value held when bit 1 went from 0 to 1, and writes to the data register while bit 1 is 1 do not change the base.
- R8: The on-the-fly sum is clamped: a negative result gives 00h and a result above 7Fh gives 7Fh.
- R9: A pulse on `slotEvt` or on `wdtEvt` sets control bits 2, 1 and 0 to 0, 0 and 1 on the next clock edge.
- R10: When an event and a control write fall in the same cycle, the event decides the guarded bits, and the key is not used up.
- R11: Index 60h (base high byte) and index 61h (base low byte) can be read and written. Any index that is not assigned reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regIdx | input | 8 | Register index for reads and writes |
| wrEn | input | 1 | Write strobe for the register at `regIdx` |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `regIdx` (combinational) |
| slotEvt | input | 1 | Slot-occupied deassertion event |
| wdtEvt | input | 1 | Watchdog timeout event |
| clkSelExt | output | 1 | Control bit 7: external clock selected |
| otfPinEn | output | 1 | Control bit 3: on-the-fly trigger on shared pin |
| cpuFamily | output | 1 | Control bit 2: processor family select |
| otfMode | output | 1 | Control bit 1: on-the-fly mode |
| extTable | output | 1 | Control bit 0: extended VID table |
| vidOut | output | 7 | VID code to the regulator |

## Verification
The hardest case to reach is an event pulse landing in the same cycle as an unlocked write to the guarded bits. In that cycle the key would normally be used up. The bench loads the key and then drives `wdtEvt` alongside the control write in one cycle. It then reads the control and key registers to show that the event set the bits and that the key is still loaded. The clamp limits are reached by entering on-the-fly mode from a known base and then writing offsets that land exactly on the limits and beyond them in both directions.

// File: rtl/vidc_pkg.sv
package vidc_pkg;

  localparam logic [7:0] IDX_CTRL    = 8'h00;
  localparam logic [7:0] IDX_OFS     = 8'h01;
  localparam logic [7:0] IDX_DATA    = 8'h02;
  localparam logic [7:0] IDX_KEY     = 8'h03;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] KEY_UNLOCK  = 8'h5A;

  // default of guarded control bits {cpuFamily, otfMode, extTable}
  localparam logic [2:0] PROT_DEFAULT = 3'b001;

  typedef struct packed {
    logic wrCtrl;
    logic wrOfs;
    logic wrVid;
    logic wrKey;
    logic wrBaseHi;
    logic wrBaseLo;
    logic pinWr;
    logic protWr;
    logic evtClr;
  } vidStrobes_t;

endpackage

// File: rtl/vidc_ctrl.sv
module vidc_ctrl
  import vidc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] regIdx,
  input  logic             wrEn,
  input  logic             keyMatch,
  input  logic             otfNow,
  input  logic             slotEvt,
  input  logic             wdtEvt,
  output vidStrobes_t      stb
);

  logic ctrlHit;

  always_comb begin
    ctrlHit      = wrEn && (regIdx == IDX_W'(IDX_CTRL));
    stb.evtClr   = slotEvt || wdtEvt;
    stb.wrCtrl   = ctrlHit;
    stb.wrOfs    = wrEn && (regIdx == IDX_W'(IDX_OFS));
    stb.wrVid    = wrEn && (regIdx == IDX_W'(IDX_DATA));
    stb.wrKey    = wrEn && (regIdx == IDX_W'(IDX_KEY));
    stb.wrBaseHi = wrEn && (regIdx == IDX_W'(IDX_BASE_HI));
    stb.wrBaseLo = wrEn && (regIdx == IDX_W'(IDX_BASE_LO));
    // trigger-pin routing may change only while on-the-fly mode is off
    stb.pinWr    = ctrlHit && !otfNow;
    // guarded write: needs the key, and an event in the same cycle wins
    stb.protWr   = ctrlHit && keyMatch && !stb.evtClr;
  end

endmodule

// File: rtl/vidc_dp.sv
module vidc_dp
  import vidc_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int VID_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  vidStrobes_t       stb,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              keyMatch,
  output logic              clkSelExt,
  output logic              otfPinEn,
  output logic              cpuFamily,
  output logic              otfMode,
  output logic              extTable,
  output logic [VID_W-1:0]  vidOut
);

  localparam int SUM_W = VID_W + 3;
  localparam logic [VID_W-1:0] VID_MAX = {VID_W{1'b1}};

  logic              clkSelQ, pinQ;
  logic [2:0]        protQ;
  logic [DATA_W-1:0] ofsQ, keyQ, baseHiQ, baseLoQ;
  logic [VID_W-1:0]  dataQ, baseQ, satCode;
  logic signed [SUM_W-1:0] sum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSelQ <= 1'b0;
      pinQ    <= 1'b0;
      protQ   <= PROT_DEFAULT;
      ofsQ    <= '0;
      keyQ    <= '0;
      dataQ   <= '0;
      baseQ   <= '0;
      baseHiQ <= '0;
      baseLoQ <= '0;
    end else begin
      if (stb.wrCtrl) clkSelQ <= wrData[7];
      if (stb.pinWr)  pinQ    <= wrData[3];
      if (stb.evtClr)      protQ <= PROT_DEFAULT;
      else if (stb.protWr) protQ <= wrData[2:0];
      if (stb.wrKey)       keyQ <= wrData;
      else if (stb.protWr) keyQ <= '0;
      if (stb.wrOfs)    ofsQ    <= wrData;
      if (stb.wrVid)    dataQ   <= wrData[VID_W-1:0];
      if (stb.wrBaseHi) baseHiQ <= wrData;
      if (stb.wrBaseLo) baseLoQ <= wrData;
      // base follows the direct code until on-the-fly mode is active
      if (!protQ[1])    baseQ   <= dataQ;
    end
  end

  assign keyMatch = (keyQ == DATA_W'(KEY_UNLOCK));

  always_comb begin
    sum = $signed({{(SUM_W-VID_W){1'b0}}, baseQ})
        + $signed({{(SUM_W-DATA_W){ofsQ[DATA_W-1]}}, ofsQ});
    if (sum < 0)
      satCode = '0;
    else if (sum > $signed({{(SUM_W-VID_W){1'b0}}, VID_MAX}))
      satCode = VID_MAX;
    else
      satCode = sum[VID_W-1:0];
  end

  assign vidOut    = protQ[1] ? satCode : dataQ;
  assign clkSelExt = clkSelQ;
  assign otfPinEn  = pinQ;
  assign cpuFamily = protQ[2];
  assign otfMode   = protQ[1];
  assign extTable  = protQ[0];

  always_comb begin
    unique case (regIdx)
      IDX_W'(IDX_CTRL):    rdData = DATA_W'({clkSelQ, 3'b000, pinQ, protQ});
      IDX_W'(IDX_OFS):     rdData = ofsQ;
      IDX_W'(IDX_DATA):    rdData = {{(DATA_W-VID_W){1'b0}}, dataQ};
      IDX_W'(IDX_KEY):     rdData = keyQ;
      IDX_W'(IDX_BASE_HI): rdData = baseHiQ;
      IDX_W'(IDX_BASE_LO): rdData = baseLoQ;
      default:             rdData = '0;
    endcase
  end

endmodule

// File: rtl/vid_key_ctrl.sv
module vid_key_ctrl
  import vidc_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int VID_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              slotEvt,
  input  logic              wdtEvt,
  output logic              clkSelExt,
  output logic              otfPinEn,
  output logic              cpuFamily,
  output logic              otfMode,
  output logic              extTable,
  output logic [VID_W-1:0]  vidOut
);

  vidStrobes_t stb;
  logic        keyMatch;

  vidc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .regIdx  (regIdx),
    .wrEn    (wrEn),
    .keyMatch(keyMatch),
    .otfNow  (otfMode),
    .slotEvt (slotEvt),
    .wdtEvt  (wdtEvt),
    .stb     (stb)
  );

  vidc_dp #(.IDX_W(IDX_W), .DATA_W(DATA_W), .VID_W(VID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regIdx   (regIdx),
    .wrData   (wrData),
    .rdData   (rdData),
    .keyMatch (keyMatch),
    .clkSelExt(clkSelExt),
    .otfPinEn (otfPinEn),
    .cpuFamily(cpuFamily),
    .otfMode  (otfMode),
    .extTable (extTable),
    .vidOut   (vidOut)
  );

endmodule

// File: rtl/vidc_checker.sv
module vidc_checker #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int VID_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [IDX_W-1:0]  regIdx,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic              slotEvt,
  input logic              wdtEvt,
  input logic              keyMatch,
  input logic              otfPinEn,
  input logic              cpuFamily,
  input logic              otfMode,
  input logic              extTable,
  input logic [VID_W-1:0]  vidOut
);

  logic evt, ctrlWr;
  assign evt    = slotEvt || wdtEvt;
  assign ctrlWr = wrEn && (regIdx == '0);

  p_evt_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> (!cpuFamily && !otfMode && extTable));

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !keyMatch && !evt) |=> $stable({cpuFamily, otfMode, extTable}));

  p_key_used_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && keyMatch && !evt) |=> !keyMatch);

  p_pin_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    otfMode |=> $stable(otfPinEn));

  p_direct_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!otfMode && regIdx == IDX_W'(8'h02)) |-> (vidOut == rdData[VID_W-1:0]));

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evt && ctrlWr && keyMatch) |=> (!otfMode && keyMatch));

endmodule

bind vid_key_ctrl vidc_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W), .VID_W(VID_W)) u_chk (.*);

// File: tb/tb_vid_key_ctrl.sv
`timescale 1ns/1ps
module tb_vid_key_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regIdx = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       slotEvt = 1'b0;
  logic       wdtEvt = 1'b0;
  logic       clkSelExt, otfPinEn, cpuFamily, otfMode, extTable;
  logic [6:0] vidOut;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  vid_key_ctrl dut (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .slotEvt(slotEvt), .wdtEvt(wdtEvt),
    .clkSelExt(clkSelExt), .otfPinEn(otfPinEn), .cpuFamily(cpuFamily),
    .otfMode(otfMode), .extTable(extTable), .vidOut(vidOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    @(negedge clk);
    regIdx = idx; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [7:0] idx, logic [7:0] exp);
    @(negedge clk);
    regIdx = idx;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic pulseEvt(bit useWdt);
    @(negedge clk);
    if (useWdt) wdtEvt = 1'b1; else slotEvt = 1'b1;
    @(negedge clk);
    wdtEvt = 1'b0; slotEvt = 1'b0;
  endtask

  task automatic t_reset;
    rdChk("R1 ctrl", 8'h00, 8'h01);
    rdChk("R1 ofs", 8'h01, 8'h00);
    rdChk("R1 data", 8'h02, 8'h00);
    rdChk("R1 key", 8'h03, 8'h00);
    rdChk("R1 baseHi", 8'h60, 8'h00);
    rdChk("R1 baseLo", 8'h61, 8'h00);
    check("R1 vidOut", {1'b0, vidOut}, 8'h00);
  endtask

  task automatic t_unprot;
    wr(8'h00, 8'hF8);  // key locked: only bits 7 and 3 may move
    rdChk("R2 ctrl reserved zero", 8'h00, 8'h89);
    check("R2 clkSelExt", {7'b0, clkSelExt}, 8'h01);
  endtask

  task automatic t_pin;
    wr(8'h03, 8'h5A);
    wr(8'h00, 8'h83);  // otf on, pin cleared (otf was 0)
    rdChk("R3 pin write while otf off", 8'h00, 8'h83);
    wr(8'h00, 8'h8B);  // pin set attempt while otf on
    check("R3 pin blocked", {7'b0, otfPinEn}, 8'h00);
    rdChk("R3 ctrl", 8'h00, 8'h83);
    pulseEvt(1'b0);
    rdChk("R9 slot clears", 8'h00, 8'h81);
  endtask

  task automatic t_key;
    wr(8'h03, 8'h33);
    rdChk("R4 key readback", 8'h03, 8'h33);
    wr(8'h00, 8'h06);
    rdChk("R4 wrong key blocks", 8'h00, 8'h01);
    rdChk("R5 key kept on blocked", 8'h03, 8'h33);
    wr(8'h03, 8'h5A);
    wr(8'h00, 8'h06);
    rdChk("R4 unlocked write", 8'h00, 8'h06);
    rdChk("R5 key consumed", 8'h03, 8'h00);
    wr(8'h00, 8'h00);
    rdChk("R5 relocked", 8'h00, 8'h06);
  endtask

  task automatic t_evt;
    pulseEvt(1'b0);
    check("R9 slot outputs", {5'b0, cpuFamily, otfMode, extTable}, 8'h01);
    wr(8'h03, 8'h5A);
    wr(8'h00, 8'h06);
    pulseEvt(1'b1);
    rdChk("R9 wdt clears", 8'h00, 8'h01);
  endtask

  task automatic t_race;
    wr(8'h03, 8'h5A);
    @(negedge clk);
    regIdx = 8'h00; wrData = 8'h06; wrEn = 1'b1; wdtEvt = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wdtEvt = 1'b0;
    rdChk("R10 event wins", 8'h00, 8'h01);
    rdChk("R10 key not used", 8'h03, 8'h5A);
    wr(8'h03, 8'h00);
  endtask

  task automatic t_direct;
    wr(8'h02, 8'hFF);
    rdChk("R6 data bit7 dropped", 8'h02, 8'h7F);
    check("R6 vidOut max", {1'b0, vidOut}, 8'h7F);
    wr(8'h02, 8'h25);
    check("R6 vidOut", {1'b0, vidOut}, 8'h25);
  endtask

  task automatic t_otf;
    wr(8'h02, 8'h40);
    wr(8'h01, 8'h10);
    wr(8'h03, 8'h5A);
    wr(8'h00, 8'h03);
    check("R7 base+ofs", {1'b0, vidOut}, 8'h50);
    wr(8'h01, 8'hF0);
    check("R7 negative ofs", {1'b0, vidOut}, 8'h30);
    wr(8'h02, 8'h10);
    check("R7 base held", {1'b0, vidOut}, 8'h30);
  endtask

  task automatic t_sat;
    // base is 40h from the entry into on-the-fly mode
    wr(8'h01, 8'h3F);
    check("R8 exact top", {1'b0, vidOut}, 8'h7F);
    wr(8'h01, 8'h7F);
    check("R8 clamp high", {1'b0, vidOut}, 8'h7F);
    wr(8'h01, 8'hC0);
    check("R8 exact zero", {1'b0, vidOut}, 8'h00);
    wr(8'h01, 8'h80);
    check("R8 clamp low", {1'b0, vidOut}, 8'h00);
  endtask

  task automatic t_base;
    wr(8'h60, 8'hAB);
    wr(8'h61, 8'hCD);
    rdChk("R11 baseHi", 8'h60, 8'hAB);
    rdChk("R11 baseLo", 8'h61, 8'hCD);
    rdChk("R11 unused index", 8'h05, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_unprot();
    t_pin();
    t_key();
    t_evt();
    t_race();
    t_direct();
    t_otf();
    t_sat();
    t_base();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule